// File: doc/BRIEF.md
# Chainable Serial Command Receiver

This block is the serial front-end of a two-channel converter controller. A host writes 16-bit command words over a three-wire link made of an active-low select, a serial clock and a data line. All three pins are brought into the system clock domain through two-flop synchronizers. Edges of the serial clock are then found by comparing the synchronized level with its value one cycle earlier. The system clock must run at least four times faster than the serial clock. While the select is low, each serial clock rising edge shifts the data bit into a 16-bit register, most significant bit first. When the select returns high, the register contents are copied to the word output, and a one-cycle valid pulse tells the downstream command decoder to act on it.

The last stage of the shift register drives a serial output, so devices can be chained by wiring that output to the next device's data input. The shift register is not cleared between frames. A frame with fewer than 16 clocks therefore delivers its bits below the tail of the earlier data, and a frame with more than 16 clocks keeps only the newest 16 bits. The command decoder supplies a launch-mode input. In mode 0 (the reset default) the serial output changes on serial clock falling edges, which gives a 16-clock lag from input to output. In mode 1 it changes on rising edges, which gives a 15.5-clock lag. The mode may be changed between frames.

The control FSM has three states:
- IDLE: select high, serial pins ignored.
- SHIFT: select low, bits accepted.
- COMMIT: the one cycle in which the latched word is flagged valid.

Its transitions are:
- IDLE→SHIFT when the synchronized select is low.
- SHIFT→COMMIT when the synchronized select is high, latching the word on that transition.
- COMMIT→IDLE unconditionally.

Top module: `serial_cmd_frontend`

## Requirements
- R1: While reset is asserted and directly after it, `word_valid` is 0, `word_data` is 0 and `sdo` is 0.
- R2: With `csn` low, each rising edge of `sck` shifts `sdi` into the register. After exactly 16 edges, `word_data[15]` holds the first bit sent and `word_data[0]` holds the last.
- R3: Each rising edge of `csn` produces exactly one `word_valid` pulse, one system clock wide, within 10 system clocks. `word_data` changes only in the cycle that pulse is high, and no pulse occurs while `csn` stays low.
- R4: While `csn` is high, toggling `sck` and `sdi` has no effect: `sdo`, `word_valid` and `word_data` stay unchanged, and the shift register contents that the next frame reports are unaltered.
- R5: A frame of N clocks delivers the last 16 bits shifted across frames. For N < 16 this is the low 16−N bits of the previous register contents in the upper positions, followed by the N new bits. For N > 16 only the final 16 bits are kept.
- R6: With `out_mode` = 0, `sdo` equals the most significant register stage captured at each falling `sck` edge and holds through the following rising edge, so it lags the input by 16 serial clocks.
- R7: With `out_mode` = 1, `sdo` takes the new most significant register stage at each rising `sck` edge, so it lags the input by 15.5 serial clocks.
- R8: `out_mode` may change while `csn` is high. The next frame then uses the new launch edge, and `sdo` does not change without an `sck` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock pin (asynchronous) |
| sdi | input | 1 | Serial data input pin (asynchronous) |
| csn | input | 1 | Active-low frame select pin (asynchronous) |
| out_mode | input | 1 | Serial output launch edge: 0 = falling, 1 = rising |
| sdo | output | 1 | Serial data output, last shift register stage |
| word_valid | output | 1 | One-cycle pulse when a frame ends |
| word_data | output | 16 | Last 16 bits shifted in, held until the next frame ends |

## Verification
The bound checker enforces four properties on every cycle:
- `word_valid` is never high for two cycles in a row.
- `word_data` changes only while `word_valid` is high.
- `sdo` never moves while the synchronized select is high.
- Each change of `sdo` follows a serial clock edge of the polarity that `out_mode` selects.

Only the bench scenarios can show the bit order, the 16 versus 15.5 clock lag, the carry-over of earlier bits into short frames, and the truncation of long frames. They do this by sweeping frame lengths from 1 to 20 in both modes against an arithmetic model of the register.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int WORD_W_DEF = 16;
    localparam int SYNC_DEF   = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } sfe_state_t;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sfe_edge.sv
module sfe_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/sfe_frame_fsm.sv
module sfe_frame_fsm
    import sfe_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_high,
    input  logic              bit_in,
    input  logic              shift_ev,
    output logic [WORD_W-1:0] shreg,
    output logic [WORD_W-1:0] word_q,
    output logic              word_valid
);
    sfe_state_t state_q, state_d;
    logic       latch_word;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        latch_word = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_high) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_high) begin
                    state_d    = ST_COMMIT;
                    latch_word = 1'b1;
                end
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        word_valid = (state_q == ST_COMMIT);
    end

    // Shift path and word latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            word_q <= '0;
        end else begin
            if (shift_ev) shreg  <= {shreg[WORD_W-2:0], bit_in};
            if (latch_word) word_q <= shreg;
        end
    end
endmodule

// File: rtl/sfe_sdo_launch.sv
module sfe_sdo_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_rise,
    input  logic rise_ev,
    input  logic fall_ev,
    input  logic msb_now,
    input  logic msb_next,
    output logic sdo_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else if (mode_rise) begin
            if (rise_ev) sdo_q <= msb_next;
        end else begin
            if (fall_ev) sdo_q <= msb_now;
        end
    end
endmodule

// File: rtl/serial_cmd_frontend.sv
module serial_cmd_frontend
    import sfe_pkg::*;
#(
    parameter int WORD_W      = WORD_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              csn,
    input  logic              out_mode,
    output logic              sdo,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);
    localparam int PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b100;

    logic [PIN_N-1:0]  pins_s;
    logic              sck_s, sdi_s, csn_s;
    logic              sck_rise_raw, sck_fall_raw;
    logic              sck_rise_g, sck_fall_g;
    logic [WORD_W-1:0] shreg;

    sfe_sync #(
        .W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({csn, sdi, sck}),
        .q_sync(pins_s)
    );

    assign sck_s = pins_s[0];
    assign sdi_s = pins_s[1];
    assign csn_s = pins_s[2];

    sfe_edge #(.RST_VAL(1'b0)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .level(sck_s),
        .rise(sck_rise_raw), .fall(sck_fall_raw)
    );

    assign sck_rise_g = sck_rise_raw & ~csn_s;
    assign sck_fall_g = sck_fall_raw & ~csn_s;

    sfe_frame_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_high(csn_s), .bit_in(sdi_s), .shift_ev(sck_rise_g),
        .shreg(shreg), .word_q(word_data), .word_valid(word_valid)
    );

    sfe_sdo_launch u_sdo (
        .clk(clk), .rst_n(rst_n), .mode_rise(out_mode),
        .rise_ev(sck_rise_g), .fall_ev(sck_fall_g),
        .msb_now(shreg[WORD_W-1]), .msb_next(shreg[WORD_W-2]),
        .sdo_q(sdo)
    );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_mode,
    input logic              sdo,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data,
    input logic              csn_s,
    input logic              rise_ev,
    input logic              fall_ev
);
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid)
        else $error("word_valid longer than one cycle");

    p_data_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_data) |-> word_valid)
        else $error("word_data changed without valid");

    p_quiet_when_deselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csn_s) |-> $stable(sdo))
        else $error("sdo moved while deselected");

    p_sdo_fall_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) && !$past(out_mode)) |-> $past(fall_ev))
        else $error("sdo moved without falling edge in mode 0");

    p_sdo_rise_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) && $past(out_mode)) |-> $past(rise_ev))
        else $error("sdo moved without rising edge in mode 1");
endmodule

bind serial_cmd_frontend sfe_checker #(.WORD_W(WORD_W)) u_sfe_checker (
    .clk(clk), .rst_n(rst_n), .out_mode(out_mode), .sdo(sdo),
    .word_valid(word_valid), .word_data(word_data), .csn_s(csn_s),
    .rise_ev(sck_rise_g), .fall_ev(sck_fall_g)
);

// File: tb/tb_serial_cmd_frontend.sv
`timescale 1ns/1ps
module tb_serial_cmd_frontend;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, sdi = 1'b0, csn = 1'b1, out_mode = 1'b0;
    logic        sdo, word_valid;
    logic [15:0] word_data;

    int   n_chk = 0, n_fail = 0, vcnt = 0;
    bit   done = 0;
    logic [15:0] mdl_sr = '0;
    logic        mdl_sdo = 1'b0;

    always #2 clk = ~clk;

    serial_cmd_frontend dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .csn(csn),
        .out_mode(out_mode), .sdo(sdo), .word_valid(word_valid),
        .word_data(word_data)
    );

    always @(posedge clk) if (word_valid) vcnt <= vcnt + 1;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic send_bit(input logic b, input string tag);
        sdi = b;
        repeat (H) @(negedge clk);
        sck = 1'b1;
        mdl_sr = {mdl_sr[14:0], b};
        if (out_mode) mdl_sdo = mdl_sr[15];
        repeat (H) @(negedge clk);
        chk(sdo === mdl_sdo, tag, sdo, mdl_sdo);
        sck = 1'b0;
        if (!out_mode) mdl_sdo = mdl_sr[15];
        repeat (H) @(negedge clk);
        chk(sdo === mdl_sdo, tag, sdo, mdl_sdo);
    endtask

    task automatic frame(input int len, input logic [31:0] pat, input string sdo_tag);
        int          v0, npulse;
        logic [15:0] cap;
        csn = 1'b0;
        v0 = vcnt;
        repeat (H) @(negedge clk);
        for (int i = 0; i < len; i++) send_bit(pat[len-1-i], sdo_tag);
        chk(vcnt == v0, "R3 no pulse in frame", vcnt, v0);
        csn = 1'b1;
        npulse = 0;
        cap = word_data;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (word_valid) begin
                npulse++;
                cap = word_data;
            end
        end
        chk(npulse == 1, "R3 pulse count", npulse, 1);
        chk(cap === mdl_sr, (len == 16) ? "R2" : "R5", cap, mdl_sr);
        chk(word_data === mdl_sr, "R3 hold", word_data, mdl_sr);
    endtask

    task automatic idle_noise(input logic [7:0] pat);
        logic        s0;
        logic [15:0] w0;
        int          v0;
        s0 = sdo; w0 = word_data; v0 = vcnt;
        for (int i = 0; i < 8; i++) begin
            sdi = pat[i];
            repeat (H) @(negedge clk);
            sck = ~sck;
            repeat (H) @(negedge clk);
        end
        sck = 1'b0;
        repeat (H) @(negedge clk);
        chk(sdo === s0, "R4 sdo", sdo, s0);
        chk(word_data === w0, "R4 word", word_data, w0);
        chk(vcnt == v0, "R4 valid", vcnt, v0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(word_valid === 1'b0, "R1 valid", word_valid, 0);
        chk(word_data === 16'h0, "R1 data", word_data, 0);
        chk(sdo === 1'b0, "R1 sdo", sdo, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(word_valid === 1'b0, "R1 valid post", word_valid, 0);
        chk(sdo === 1'b0, "R1 sdo post", sdo, 0);

        // Full-length frames, mode 0
        frame(16, 32'h0000_A5C3, "R6");
        frame(16, 32'h0000_8001, "R6");
        idle_noise(8'hB4);
        frame(16, 32'h0000_7FFE, "R4 R6");

        // Length sweep in both modes
        for (int m = 0; m < 2; m++) begin
            out_mode = m[0];
            repeat (H) @(negedge clk);
            chk(sdo === mdl_sdo, "R8 switch", sdo, mdl_sdo);
            for (int len = 1; len <= 20; len++) begin
                frame(len, 32'h9E37_79B1 * len ^ 32'h5A5A_3C3C,
                      (len == 1) ? "R8" : (m == 0) ? "R6" : "R7");
                if (len % 5 == 0) idle_noise(len[7:0] * 8'h3B);
            end
        end

        // Alternate modes frame by frame
        for (int j = 0; j < 6; j++) begin
            out_mode = j[0];
            frame(16, 32'hC0DE_0000 >> j, "R8");
        end

        done = 1;
        finish_run();
    end
endmodule